// File: doc/BRIEF.md
# Pipelined Converter Sampler with Live Serial Streaming

This block drives an external 8-bit successive-approximation converter that has a parallel data bus. It sends every result to a host over an asynchronous serial transmitter, with no sample memory in between. A divider of the system clock produces a sample tick at a fixed rate. On each tick the block starts a new conversion and, in the same moment, starts sending the result it read during the previous period. The current conversion and the serial transfer of the previous result therefore overlap, so samples stream live at the full sampling rate.

Each conversion follows a fixed handshake. The block pulses an active-low start line. It waits for the converter's active-low completion line, then drives an active-low read strobe and captures the data bus. The captured byte waits in a single holding register until the next tick sends it. If the transmitter is still busy at that tick, the held byte is dropped and a sticky overrun flag is raised.

A separate square-wave generator with a 50 percent duty cycle and a programmable half period is provided for self-test. With the defaults (27 MHz clock, 8 kHz sample rate, 115200 baud), one serial frame takes 2340 cycles, which fits inside the 3375-cycle sample period.

Top module: `adc_streamer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls: `adc_wr_n`, `adc_rd_n` and `txd` are 1, and `overrun` and `sq_out` are 0.
- R2: Consecutive falling edges of `adc_wr_n` are exactly round(CLK_HZ/SAMPLE_HZ) cycles apart (3375 with the defaults), unless a tick is skipped under R7.
- R3: Each conversion start holds `adc_wr_n` low for exactly WR_CYC cycles (default 4). `adc_wr_n` and `adc_rd_n` are never low in the same cycle.
- R4: `adc_rd_n` falls only after `adc_done_n` has been seen low. It stays low for RD_CYC cycles (default 2), and the bus value is captured during that window. The bytes sent on `txd` equal the captured values, in capture order, with none lost when the transmitter keeps up.
- R5: When a captured byte is waiting at a tick, its start bit appears on `txd` exactly one cycle after `adc_wr_n` falls for the new conversion.
- R6: `txd` idles at 1. Each frame is one start bit (0), eight data bits least significant first, and one stop bit (1). Every bit lasts round(CLK_HZ/BAUD) cycles (234 with the defaults).
- R7: A tick that arrives before the previous conversion has been read produces no write pulse. The late result is still read when `adc_done_n` falls, and it is sent at the next tick.
- R8: If a byte is waiting at a tick while the transmitter is busy, that byte is discarded and `overrun` goes to 1. `overrun` then stays at 1 until reset.
- R9: For a nonzero `sq_half`, `sq_out` alternates between high and low phases, each exactly `sq_half` cycles long.
- R10: While `sq_half` is 0, `sq_out` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | 8 | Converter parallel result bus |
| adc_done_n | input | 1 | Converter completion, active low, asynchronous |
| adc_wr_n | output | 1 | Conversion start pulse, active low |
| adc_rd_n | output | 1 | Result read strobe, active low |
| txd | output | 1 | Serial transmit line, 8N1 |
| overrun | output | 1 | Sticky flag: a byte was dropped because the transmitter was busy |
| sq_half | input | 16 | Square-wave half period in cycles; 0 stops the output |
| sq_out | output | 1 | Self-test square wave |

## Verification
The assertions assume the converter behaves as follows:
- After a start pulse it drives `adc_done_n` low.
- It keeps `adc_done_n` low until the read strobe falls.
- It releases `adc_done_n` once the read strobe is seen.

The converter model in the bench follows exactly that protocol. It normally completes 60 cycles after the start pulse ends. For one conversion it is deliberately delayed past the next tick, to exercise the skipped-tick path.

A second instance uses scaled-down rates and a converter whose completion line is always low. That makes the serial frame longer than the sample period, so the overrun path is reached. Its completion line is already low when the read strobe falls, which still satisfies the read-after-done property.

// File: rtl/adc_streamer_pkg.sv
package adc_streamer_pkg;

    localparam int unsigned SAMPLE_W = 8;

    typedef enum logic [1:0] {
        CV_IDLE,
        CV_WRITE,
        CV_WAIT,
        CV_READ
    } conv_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] value;
    } sample_t;

    // Rounded integer ratio, used for clock dividers
    function automatic int unsigned ratio_cycles(input int unsigned num, input int unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/sample_timer.sv
module sample_timer #(
    parameter int unsigned DIV = 3375
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == W'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
    import adc_streamer_pkg::*;
#(
    parameter int unsigned WR_CYC = 4,
    parameter int unsigned RD_CYC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                done_n,
    input  logic [SAMPLE_W-1:0] data_in,
    output logic                wr_n,
    output logic                rd_n,
    output sample_t             sample_o
);
    localparam int unsigned CW = $clog2(WR_CYC + RD_CYC + 1);

    conv_state_e   state;
    logic [CW-1:0] cnt;
    logic [1:0]    done_sync;
    logic          done_s;

    assign done_s = done_sync[1];

    // The completion line is asynchronous to clk, so it passes two flops
    always_ff @(posedge clk) begin
        if (rst) done_sync <= 2'b11;
        else     done_sync <= {done_sync[0], done_n};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CV_IDLE;
            cnt      <= '0;
            wr_n     <= 1'b1;
            rd_n     <= 1'b1;
            sample_o <= '0;
        end else begin
            sample_o.valid <= 1'b0;
            unique case (state)
                CV_IDLE: begin
                    // A tick in any other state is dropped (skipped conversion)
                    if (tick) begin
                        wr_n  <= 1'b0;
                        cnt   <= '0;
                        state <= CV_WRITE;
                    end
                end
                CV_WRITE: begin
                    if (cnt == CW'(WR_CYC - 1)) begin
                        wr_n  <= 1'b1;
                        state <= CV_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CV_WAIT: begin
                    if (!done_s) begin
                        rd_n  <= 1'b0;
                        cnt   <= '0;
                        state <= CV_READ;
                    end
                end
                CV_READ: begin
                    if (cnt == CW'(RD_CYC - 1)) begin
                        rd_n           <= 1'b1;
                        sample_o.valid <= 1'b1;
                        sample_o.value <= data_in;
                        state          <= CV_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= CV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import adc_streamer_pkg::*;
#(
    parameter int unsigned BIT_DIV = 234
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SAMPLE_W-1:0] data,
    output logic                txd,
    output logic                busy
);
    localparam int unsigned DW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
    localparam int unsigned BW = $clog2(SAMPLE_W);

    tx_state_e           state;
    logic [DW-1:0]       divc;
    logic [BW-1:0]       bitn;
    logic [SAMPLE_W-1:0] shreg;
    logic                bit_end;

    assign bit_end = (divc == DW'(BIT_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            divc  <= '0;
            bitn  <= '0;
            shreg <= '0;
            txd   <= 1'b1;
            busy  <= 1'b0;
        end else begin
            if (state != TX_IDLE) divc <= bit_end ? '0 : divc + 1'b1;
            unique case (state)
                TX_IDLE: begin
                    if (start) begin
                        shreg <= data;
                        txd   <= 1'b0;
                        busy  <= 1'b1;
                        divc  <= '0;
                        state <= TX_START;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        txd   <= shreg[0];
                        shreg <= shreg >> 1;
                        bitn  <= '0;
                        state <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        if (bitn == BW'(SAMPLE_W - 1)) begin
                            txd   <= 1'b1;
                            state <= TX_STOP;
                        end else begin
                            txd   <= shreg[0];
                            shreg <= shreg >> 1;
                            bitn  <= bitn + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        busy  <= 1'b0;
                        state <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/square_gen.sv
module square_gen #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] half,
    output logic         sq
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || half == '0) begin
            cnt <= '0;
            sq  <= 1'b0;
        end else if (cnt >= half - 1'b1) begin
            cnt <= '0;
            sq  <= ~sq;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_streamer.sv
module adc_streamer
    import adc_streamer_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 27_000_000,
    parameter int unsigned SAMPLE_HZ = 8_000,
    parameter int unsigned BAUD      = 115_200,
    parameter int unsigned WR_CYC    = 4,
    parameter int unsigned RD_CYC    = 2,
    parameter int unsigned SQ_W      = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                adc_done_n,
    output logic                adc_wr_n,
    output logic                adc_rd_n,
    output logic                txd,
    output logic                overrun,
    input  logic [SQ_W-1:0]     sq_half,
    output logic                sq_out
);
    localparam int unsigned SAMPLE_DIV = ratio_cycles(CLK_HZ, SAMPLE_HZ);
    localparam int unsigned BIT_DIV    = ratio_cycles(CLK_HZ, BAUD);

    logic                tick;
    sample_t             captured;
    sample_t             pend;
    logic                tx_start;
    logic [SAMPLE_W-1:0] tx_data;
    logic                tx_busy;
    logic                overrun_q;

    sample_timer #(.DIV(SAMPLE_DIV)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    adc_sequencer #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .done_n   (adc_done_n),
        .data_in  (adc_data),
        .wr_n     (adc_wr_n),
        .rd_n     (adc_rd_n),
        .sample_o (captured)
    );

    // Single holding slot between capture and transmission
    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            tx_start  <= 1'b0;
            tx_data   <= '0;
            overrun_q <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            if (tick && pend.valid) begin
                pend.valid <= 1'b0;
                if (tx_busy) begin
                    overrun_q <= 1'b1;
                end else begin
                    tx_start <= 1'b1;
                    tx_data  <= pend.value;
                end
            end
            if (captured.valid) pend <= captured;
        end
    end

    assign overrun = overrun_q;

    uart_tx #(.BIT_DIV(BIT_DIV)) tx_i (
        .clk   (clk),
        .rst   (rst),
        .start (tx_start),
        .data  (tx_data),
        .txd   (txd),
        .busy  (tx_busy)
    );

    square_gen #(.W(SQ_W)) sq_i (
        .clk  (clk),
        .rst  (rst),
        .half (sq_half),
        .sq   (sq_out)
    );
endmodule

// File: rtl/adc_streamer_chk.sv
module adc_streamer_chk #(
    parameter int unsigned SQ_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            adc_done_n,
    input logic            adc_wr_n,
    input logic            adc_rd_n,
    input logic            txd,
    input logic            tx_busy,
    input logic            overrun,
    input logic [SQ_W-1:0] sq_half,
    input logic            sq_out
);
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!adc_wr_n && !adc_rd_n));

    a_r4_read_after_done: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_rd_n) |-> !$past(adc_done_n));

    a_r6_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r10_square_held_low: assert property (@(posedge clk) disable iff (rst)
        (sq_half == '0) |=> !sq_out);
endmodule

bind adc_streamer adc_streamer_chk #(.SQ_W(SQ_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .adc_done_n (adc_done_n),
    .adc_wr_n   (adc_wr_n),
    .adc_rd_n   (adc_rd_n),
    .txd        (txd),
    .tx_busy    (tx_busy),
    .overrun    (overrun),
    .sq_half    (sq_half),
    .sq_out     (sq_out)
);

// File: tb/adc_streamer_tb_top.sv
`timescale 1ns/1ps
module adc_streamer_tb_top;
    localparam int PERIOD = 3375;
    localparam int BITC   = 234;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Main instance (default rates)
    logic [7:0]  adc_val = 8'h3C;
    logic        done_n  = 1'b1;
    logic        adc_wr_n, adc_rd_n, txd, overrun, sq_out;
    logic [15:0] sq_half = 16'd0;

    adc_streamer dut_i (
        .clk(clk), .rst(rst), .adc_data(adc_val), .adc_done_n(done_n),
        .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .txd(txd),
        .overrun(overrun), .sq_half(sq_half), .sq_out(sq_out)
    );

    // Scaled instance whose serial frame outlasts the sample period
    logic wr2_n, rd2_n, txd2, overrun2, sq2;
    adc_streamer #(.CLK_HZ(2700), .SAMPLE_HZ(100), .BAUD(100)) ovr_i (
        .clk(clk), .rst(rst), .adc_data(8'hA5), .adc_done_n(1'b0),
        .adc_wr_n(wr2_n), .adc_rd_n(rd2_n), .txd(txd2),
        .overrun(overrun2), .sq_half(16'd0), .sq_out(sq2)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter model and scoreboard producer
    logic [7:0] exp_q[$];
    bit   stall_req = 1'b0;
    int   conv_left = -1;
    logic wr_prev = 1'b1, rd_prev = 1'b1;

    always @(negedge clk) begin
        if (wr_prev && !adc_wr_n) done_n = 1'b1;
        if (!wr_prev && adc_wr_n) begin
            conv_left = stall_req ? PERIOD + 500 : 60;
        end else if (conv_left > 0) begin
            conv_left--;
            if (conv_left == 0) done_n = 1'b0;
        end
        if (rd_prev && !adc_rd_n) done_n = 1'b1;
        if (!rd_prev && adc_rd_n) begin
            exp_q.push_back(adc_val);
            adc_val = adc_val + 8'd53;
        end
        wr_prev = adc_wr_n;
        rd_prev = adc_rd_n;
    end

    // Serial monitor: decodes frames and compares against the queue
    int bytes_rx = 0;
    initial begin
        logic p;
        logic [7:0] b;
        logic [7:0] e;
        p = 1'b1;
        forever begin
            @(negedge clk);
            if (p && !txd && !rst) begin
                repeat (BITC / 2) @(negedge clk);
                chk(txd == 1'b0, "R6", "start bit level", int'(txd), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    b[i] = txd;
                end
                repeat (BITC) @(negedge clk);
                chk(txd == 1'b1, "R6", "stop bit level", int'(txd), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected byte", int'(b), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(b == e, "R4", "streamed byte", int'(b), int'(e));
                end
                bytes_rx++;
            end
            p = txd;
        end
    end

    task automatic wait_wr_fall(output int c);
        logic p;
        bit   seen;
        p    = adc_wr_n;
        seen = 1'b0;
        while (!seen) begin
            @(negedge clk);
            if (p && !adc_wr_n) begin
                c    = cyc;
                seen = 1'b1;
            end
            p = adc_wr_n;
        end
    endtask

    task automatic measure_sq(input int half, input string req);
        int hi, lo;
        logic p;
        p = sq_out;
        while (!(p == 1'b0 && sq_out == 1'b1)) begin
            p = sq_out;
            @(negedge clk);
        end
        hi = 0;
        while (sq_out) begin hi++; @(negedge clk); end
        lo = 0;
        while (!sq_out) begin lo++; @(negedge clk); end
        chk(hi == half, req, "square high phase", hi, half);
        chk(lo == half, req, "square low phase", lo, half);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int w1, w2, w3, w4, w5, n, rel;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(adc_wr_n == 1'b1, "R1", "wr_n in reset", int'(adc_wr_n), 1);
        chk(adc_rd_n == 1'b1, "R1", "rd_n in reset", int'(adc_rd_n), 1);
        chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
        chk(overrun == 1'b0, "R1", "overrun in reset", int'(overrun), 0);
        chk(sq_out == 1'b0, "R1", "sq_out in reset", int'(sq_out), 0);
        chk(overrun2 == 1'b0, "R1", "overrun of scaled instance in reset", int'(overrun2), 0);
        rst = 1'b0;
        rel = cyc;
        @(negedge clk);
        chk(adc_wr_n == 1'b1 && txd == 1'b1, "R1", "idle after reset", int'(adc_wr_n & txd), 1);

        // R8 on the scaled instance: second tick sends, third tick overruns
        repeat (60) @(negedge clk);
        chk(overrun2 == 1'b0, "R8", "no overrun before busy tick", int'(overrun2), 0);
        repeat (140) @(negedge clk);
        chk(overrun2 == 1'b1, "R8", "overrun raised", int'(overrun2), 1);

        // R2 / R3 on the main instance
        wait_wr_fall(w1);
        n = 1;
        @(negedge clk);
        while (!adc_wr_n) begin n++; @(negedge clk); end
        chk(n == 4, "R3", "write pulse width", n, 4);
        wait_wr_fall(w2);
        chk(w2 - w1 == PERIOD, "R2", "tick spacing", w2 - w1, PERIOD);
        // R5 overlap: start bit one cycle after the write pulse begins
        chk(txd == 1'b1, "R5", "txd at write edge", int'(txd), 1);
        @(negedge clk);
        chk(txd == 1'b0, "R5", "start bit one cycle later", int'(txd), 0);
        wait_wr_fall(w3);
        chk(w3 - w2 == PERIOD, "R2", "tick spacing 2", w3 - w2, PERIOD);

        // R7: stall the fourth conversion past the following tick
        repeat (8) @(negedge clk);
        stall_req = 1'b1;
        wait_wr_fall(w4);
        chk(w4 - w3 == PERIOD, "R2", "tick spacing 3", w4 - w3, PERIOD);
        repeat (8) @(negedge clk);
        stall_req = 1'b0;
        wait_wr_fall(w5);
        chk(w5 - w4 == 2 * PERIOD, "R7", "skipped tick spacing", w5 - w4, 2 * PERIOD);

        while (bytes_rx < 5) @(negedge clk);
        chk(bytes_rx >= 5, "R4", "bytes streamed", bytes_rx, 5);
        chk(overrun == 1'b0, "R8", "no overrun when transmitter keeps up", int'(overrun), 0);

        // R9 / R10 square wave
        sq_half = 16'd10;
        measure_sq(10, "R9");
        sq_half = 16'd37;
        measure_sq(37, "R9");
        sq_half = 16'd0;
        repeat (3) @(negedge clk);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            if (sq_out) n++;
            @(negedge clk);
        end
        chk(n == 0, "R10", "high cycles with zero half period", n, 0);

        chk(overrun2 == 1'b1, "R8", "overrun stays set", int'(overrun2), 1);
        chk(cyc - rel > 0, "R2", "time advanced", cyc - rel, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule